// File: doc/BRIEF.md
# Multichannel Pulse Counter Bank

This block keeps running tallies of pulse activity on a set of channels. Each channel has two pulse lines, one for the pulses it receives and one for the pulses it emits. Each line has its own counter. The pulse lines must already be synchronous to the system clock. The block finds rising edges by comparing each line with a copy delayed by one cycle, and adds one to the matching counter for each edge it finds.

Software reads the counters over a simple word-addressed 32-bit slave bus with cycle, strobe and write-enable qualifiers. The two counters of a channel occupy adjacent words: the receive count comes first, then the emit count. The word just past the last counter is a clear command. Writing a 1 to its lowest bit sets every counter to zero at once. Every access is answered with a one-cycle acknowledge, including accesses to words that hold nothing.

Top module: `pulse_tally_bank`

## Requirements
- R1: While `rst_n` is low, every counter is zero and `bus_ack` is low. After `rst_n` is released, every counter word reads 0.
- R2: A counter adds exactly one for each low-to-high transition of its line. A line held high for several cycles counts once. A line that stays low never counts.
- R3: Word address 2k holds the receive count of channel k (bit k of `in_pulse`). Word address 2k+1 holds the emit count of channel k (bit k of `out_pulse`). Both are zero-extended to 32 bits.
- R4: A write to any counter word leaves every count unchanged.
- R5: A write to word address 2·NCH (12 by default) with bit 0 of the write data at 1 zeroes all counters on the clock edge that samples the write. With bit 0 at 0, the write changes nothing. A read of this word returns 0.
- R6: An access sampled with `bus_cyc` and `bus_stb` high is acknowledged by a `bus_ack` that is high for exactly one cycle, starting at the next edge. Read data is valid in that cycle. `bus_stall` is high whenever `bus_cyc` and `bus_stb` are high and `bus_ack` is low.
- R7: An access to an address above the clear word is still acknowledged, and a read of it returns 0.
- R8: Counters are CW bits wide (32 by default). A counter at its maximum value wraps to 0 on the next edge and does not saturate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_pulse | input | NCH | Receive pulse line per channel |
| out_pulse | input | NCH | Emit pulse line per channel |
| bus_cyc | input | 1 | Bus cycle qualifier |
| bus_stb | input | 1 | Bus strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_adr | input | AW | Word address |
| bus_wdat | input | DW | Write data, only bit 0 is used, by the clear word |
| bus_rdat | output | DW | Read data, valid while `bus_ack` is high |
| bus_ack | output | 1 | One-cycle access acknowledge |
| bus_stall | output | 1 | Access pending, not yet acknowledged |

## Verification
A rising edge on a pulse line shows up in its counter one edge after it is sampled. Read data and the acknowledge appear one edge after the strobe is sampled, and a clear takes effect on the same edge as the write it comes from. The bench changes inputs only on falling edges. It raises a pulse line for one full cycle and brings it back low before any read starts. It checks acknowledge and read data at the falling edge that follows the accepting rising edge, so every expected value is compared in the cycle when it is due. For the wrap case the bench uses a narrower counter width, which keeps the number of pulses needed small.

// File: rtl/pulse_tally_bank.sv
module pulse_tally_bank #(
  parameter int NCH = 6,
  parameter int CW  = 32,
  parameter int DW  = 32,
  parameter int AW  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NCH-1:0] in_pulse,
  input  logic [NCH-1:0] out_pulse,
  input  logic          bus_cyc,
  input  logic          bus_stb,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_adr,
  input  logic [DW-1:0] bus_wdat,
  output logic [DW-1:0] bus_rdat,
  output logic          bus_ack,
  output logic          bus_stall
);
  localparam int NWORD = 2 * NCH;
  localparam logic [AW-1:0] CLR_ADR = AW'(NWORD);

  logic [NWORD-1:0] line, line_d, rise;
  logic [CW-1:0]    cnt [NWORD];
  logic             ack_q, accept, clr;
  logic [DW-1:0]    rd_word, rdat_q;

  assign accept    = bus_cyc & bus_stb & ~ack_q;
  assign clr       = accept & bus_we & (bus_adr == CLR_ADR) & bus_wdat[0];
  assign rise      = line & ~line_d;
  assign bus_ack   = ack_q;
  assign bus_rdat  = rdat_q;
  assign bus_stall = bus_cyc & bus_stb & ~ack_q;

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_map
      assign line[2*c]   = in_pulse[c];
      assign line[2*c+1] = out_pulse[c];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) line_d <= '0;
    else        line_d <= line;

  generate
    for (genvar k = 0; k < NWORD; k++) begin : g_cnt
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)       cnt[k] <= '0;
        else if (clr)     cnt[k] <= '0;
        else if (rise[k]) cnt[k] <= cnt[k] + 1'b1;

      // R2
      inc_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && rise[k]) |=> cnt[k] == $past(cnt[k]) + 1'b1);
      // R4
      hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !rise[k]) |=> $stable(cnt[k]));
      // R5
      clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt[k] == '0);
    end
  endgenerate

  always_comb begin
    rd_word = '0;
    for (int k = 0; k < NWORD; k++)
      if (bus_adr == AW'(k)) rd_word[CW-1:0] = cnt[k];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ack_q  <= 1'b0;
      rdat_q <= '0;
    end else begin
      ack_q <= accept;
      if (accept) rdat_q <= bus_we ? '0 : rd_word;
    end

  // R6
  ack_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |=> !bus_ack);
  // R6
  ack_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && bus_stb && !bus_ack) |=> bus_ack);
  // R7
  unused_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && bus_stb && !bus_ack && !bus_we && bus_adr > CLR_ADR) |=> bus_rdat == '0);
endmodule

// File: tb/pulse_tally_bank_tb.sv
module pulse_tally_bank_tb_top;
  localparam int PERIOD = 10;
  localparam int NCH = 6, CW = 8, DW = 32, AW = 4, NW = 2 * NCH;
  localparam int NVEC = 4;
  // {in_mask[19:14], out_mask[13:8], pulses[7:0]}
  localparam logic [19:0] VEC [NVEC] = '{
    {6'b000001, 6'b000000, 8'd3},
    {6'b101010, 6'b010101, 8'd5},
    {6'b111111, 6'b111111, 8'd2},
    {6'b000000, 6'b100001, 8'd7}
  };

  logic clk = 0, rst_n = 0;
  logic [NCH-1:0] in_pulse = '0, out_pulse = '0;
  logic bus_cyc = 0, bus_stb = 0, bus_we = 0;
  logic [AW-1:0] bus_adr = '0;
  logic [DW-1:0] bus_wdat = '0;
  logic [DW-1:0] bus_rdat;
  logic bus_ack, bus_stall;
  int checks = 0, errors = 0;
  int expc [NW];

  always #(PERIOD/2) clk = ~clk;

  pulse_tally_bank #(.NCH(NCH), .CW(CW), .DW(DW), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_pulse(in_pulse), .out_pulse(out_pulse),
    .bus_cyc(bus_cyc), .bus_stb(bus_stb), .bus_we(bus_we), .bus_adr(bus_adr),
    .bus_wdat(bus_wdat), .bus_rdat(bus_rdat), .bus_ack(bus_ack), .bus_stall(bus_stall));

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulses(input logic [NCH-1:0] im, input logic [NCH-1:0] om, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); in_pulse = im; out_pulse = om;
      @(negedge clk); in_pulse = '0; out_pulse = '0;
    end
    @(negedge clk);
  endtask

  task automatic access(input string req, input logic we, input int a,
                        input logic [DW-1:0] wd, output logic [DW-1:0] rd);
    @(negedge clk);
    bus_cyc = 1; bus_stb = 1; bus_we = we; bus_adr = AW'(a); bus_wdat = wd;
    #1 chk({req, " stall"}, bus_stall, 1);
    @(negedge clk);
    chk({req, " ack"}, bus_ack, 1);
    rd = bus_rdat;
    bus_cyc = 0; bus_stb = 0; bus_we = 0;
    @(negedge clk);
    chk({req, " ack drop"}, bus_ack, 0);
  endtask

  task automatic read_all(input string req);
    logic [DW-1:0] r;
    for (int k = 0; k < NW; k++) begin
      access(req, 0, k, '0, r);
      chk(req, r, expc[k] % (1 << CW));
    end
  endtask

  initial begin
    logic [DW-1:0] r;
    int acks;
    for (int k = 0; k < NW; k++) expc[k] = 0;
    // R1
    #(PERIOD*2) chk("R1 ack in reset", bus_ack, 0);
    @(negedge clk); rst_n = 1;
    read_all("R1");

    // R2 R3 table walk
    for (int v = 0; v < NVEC; v++) begin
      pulses(VEC[v][19:14], VEC[v][13:8], int'(VEC[v][7:0]));
      for (int c = 0; c < NCH; c++) begin
        if (VEC[v][14+c]) expc[2*c]   += int'(VEC[v][7:0]);
        if (VEC[v][8+c])  expc[2*c+1] += int'(VEC[v][7:0]);
      end
      read_all("R3 R2 table");
    end

    // R2: long high level counts once
    @(negedge clk); in_pulse[2] = 1;
    repeat (5) @(negedge clk);
    in_pulse[2] = 0; expc[4] += 1;
    access("R2 level", 0, 4, '0, r);
    chk("R2 level", r, expc[4]);

    // R4: write to count word has no effect
    access("R4", 1, 3, 32'hFFFF_FFFF, r);
    access("R4", 0, 3, '0, r);
    chk("R4 write ignored", r, expc[3]);

    // R5: write 0 to clear word does nothing
    access("R5", 1, NW, 32'h0, r);
    access("R5", 0, 0, '0, r);
    chk("R5 zero write", r, expc[0]);
    access("R5", 0, NW, '0, r);
    chk("R5 clear word reads 0", r, 0);
    access("R5", 1, NW, 32'h1, r);
    for (int k = 0; k < NW; k++) expc[k] = 0;
    read_all("R5 cleared");

    // R7: unused addresses
    access("R7", 0, NW + 1, '0, r);
    chk("R7 unused 13", r, 0);
    access("R7", 0, 15, '0, r);
    chk("R7 unused 15", r, 0);

    // R6: strobe held four cycles gives two non-adjacent acks
    @(negedge clk); bus_cyc = 1; bus_stb = 1; bus_adr = '0;
    acks = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (bus_ack) begin
        acks++;
        chk("R6 stall low with ack", bus_stall, 0);
      end else chk("R6 stall high while pending", bus_stall, 1);
    end
    bus_cyc = 0; bus_stb = 0;
    chk("R6 ack count", acks, 2);
    @(negedge clk);

    // R8: wrap at CW bits
    pulses(6'b000001, '0, 255);
    access("R8", 0, 0, '0, r);
    chk("R8 max", r, 255);
    pulses(6'b000001, '0, 3);
    access("R8", 0, 0, '0, r);
    chk("R8 wrap", r, 2);

    // R1: reset mid-run
    pulses('0, 6'b111111, 4);
    @(negedge clk); rst_n = 0;
    @(negedge clk); chk("R1 ack low", bus_ack, 0);
    rst_n = 1;
    for (int k = 0; k < NW; k++) expc[k] = 0;
    read_all("R1 after reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD*150000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule